// File: doc/BRIEF.md
# Single-Cycle 16-Bit Processor Core

This block is a small processor core. It completes one instruction in every clock cycle. On each cycle it presents the program counter on an instruction port. It decodes the returned 16-bit word and reads its operands from a sixteen-entry register file. It then computes a result and, at the rising edge that closes the cycle, commits that result to a register, to data memory, or to the program counter. Code and data are word-addressed, so every address names one 16-bit word. Both memories sit outside the block and must answer reads within the same cycle. Memory-mapped devices attach through the data port in the same way as ordinary RAM.

Arithmetic, logic, shift and multiply operations take two register operands. Loads and stores always form their address from register r13 plus a signed 8-bit offset. Conditional branches test a single register against zero and move the PC by a signed offset measured from the next instruction. A jump-and-link instruction saves the return address and jumps to the address held in a register. A pair of instructions builds any 16-bit constant: one loads an unsigned byte into the upper half of a register, and the other adds a signed byte to that register.

Top module: `sc16_core`

## Requirements
- R1: Opcode sits in bits 15..12. Register-form words hold the destination in bits 11..8, the first source in 7..4 and the second source in 3..0. Immediate-form words hold the register in 11..8 and an 8-bit constant in 7..0.
- R2: A synchronous active-high reset sets the PC to 0 and every register to 0.
- R3: Register 0 always reads as zero, and any result aimed at it is dropped.
- R4: Register-form opcodes give 0000 sum, 0001 difference, 0010 AND, 0011 OR, 0100 XOR, 0101 signed less-than as 0 or 1, 0110 left shift by the low 4 bits of the second source, 0111 low 16 bits of the product, and 1110 zero-filling right shift by the low 4 bits. All of them wrap at 16 bits.
- R5: Opcode 1000 loads the destination from the data word at r13 plus the sign-extended constant.
- R6: Opcode 1001 writes the named register to the data word at r13 plus the sign-extended constant and leaves every register unchanged. No other opcode asserts the data write enable.
- R7: Opcode 1010 jumps to PC+1+sign-extended constant when the named register is zero. Opcode 1011 does so when it is nonzero. Otherwise both continue at PC+1.
- R8: Opcode 1100 writes the constant, taken as unsigned, into the upper byte and clears the lower byte.
- R9: Opcode 1101 adds the sign-extended constant to the named register and wraps at 16 bits.
- R10: Opcode 1111 writes PC+1 into the destination and continues at the first-source register's value, whatever the bits 3..0 hold.
- R11: Every instruction that is not a taken branch or a jump is followed by the instruction at PC+1.
- R12: A program that sums 1..8 in a backward-branch loop leaves 36 in r9, and the constant pair 0xBF / -17 yields 0xBEEF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 16 | Word address of the instruction being executed (the PC) |
| imem_data | input | 16 | Instruction word at imem_addr, valid in the same cycle |
| dmem_addr | output | 16 | Word address for load or store |
| dmem_wdata | output | 16 | Store data |
| dmem_we | output | 1 | Store strobe, taken at the rising edge |
| dmem_rdata | input | 16 | Load data at dmem_addr, valid in the same cycle |

## Verification
An instruction can read a register and write that same register within one cycle. The constant-add instruction does this, and so does an accumulate such as r2 = r2 + r1. The operand must be the old value, and the new value must only become visible on the next instruction. The bench provokes this with the constant pairs and with the summing loop, where each pass reads and updates the same registers. The check is on the stored results: the loop must give exactly 36, and 0xFF00 plus 0x7F must give 0xFF7F. Any sign of a same-cycle forwarding loop or a one-cycle lag changes those numbers.

// File: rtl/sc16_pkg.sv
package sc16_pkg;

  localparam int unsigned INSN_W = 16;
  localparam int unsigned OPC_W  = 4;
  localparam int unsigned RIDX_W = 4;
  localparam int unsigned IMM_W  = 8;

  typedef enum logic [OPC_W-1:0] {
    OPC_ADD   = 4'h0,
    OPC_SUB   = 4'h1,
    OPC_AND   = 4'h2,
    OPC_OR    = 4'h3,
    OPC_XOR   = 4'h4,
    OPC_SLT   = 4'h5,
    OPC_SHL   = 4'h6,
    OPC_MUL   = 4'h7,
    OPC_LOAD  = 4'h8,
    OPC_STORE = 4'h9,
    OPC_BRZ   = 4'hA,
    OPC_BRNZ  = 4'hB,
    OPC_UPPER = 4'hC,
    OPC_ADDI  = 4'hD,
    OPC_SHR   = 4'hE,
    OPC_JLINK = 4'hF
  } opc_e;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR,
    ALU_SLT, ALU_SHL, ALU_MUL, ALU_SHR
  } alu_fn_e;

  typedef enum logic [1:0] {
    WB_ALU, WB_MEM, WB_LINK, WB_UPPER
  } wb_sel_e;

  typedef struct packed {
    alu_fn_e alu_fn;
    logic    b_imm;
    logic    rf_we;
    wb_sel_e wb_sel;
    logic    mem_we;
    logic    br_on_zero;
    logic    br_on_nz;
    logic    jump;
  } ctrl_t;

endpackage

// File: rtl/sc16_decode.sv
module sc16_decode
  import sc16_pkg::*;
#(
  parameter logic [RIDX_W-1:0] BASE_REG = 4'd13
) (
  input  logic [INSN_W-1:0] insn,
  output ctrl_t             ctrl,
  output logic [RIDX_W-1:0] ra_a,
  output logic [RIDX_W-1:0] ra_b,
  output logic [RIDX_W-1:0] wa,
  output logic [IMM_W-1:0]  imm8
);

  opc_e              opc;
  logic [RIDX_W-1:0] f_dst;
  logic [RIDX_W-1:0] f_src1;
  logic [RIDX_W-1:0] f_src2;

  assign opc    = opc_e'(insn[15:12]);
  assign f_dst  = insn[11:8];
  assign f_src1 = insn[7:4];
  assign f_src2 = insn[3:0];
  assign imm8   = insn[7:0];
  assign wa     = f_dst;

  always_comb begin
    ctrl.alu_fn     = ALU_ADD;
    ctrl.b_imm      = 1'b0;
    ctrl.rf_we      = 1'b1;
    ctrl.wb_sel     = WB_ALU;
    ctrl.mem_we     = 1'b0;
    ctrl.br_on_zero = 1'b0;
    ctrl.br_on_nz   = 1'b0;
    ctrl.jump       = 1'b0;
    ra_a            = f_src1;
    ra_b            = f_src2;
    case (opc)
      OPC_ADD:   ctrl.alu_fn = ALU_ADD;
      OPC_SUB:   ctrl.alu_fn = ALU_SUB;
      OPC_AND:   ctrl.alu_fn = ALU_AND;
      OPC_OR:    ctrl.alu_fn = ALU_OR;
      OPC_XOR:   ctrl.alu_fn = ALU_XOR;
      OPC_SLT:   ctrl.alu_fn = ALU_SLT;
      OPC_SHL:   ctrl.alu_fn = ALU_SHL;
      OPC_MUL:   ctrl.alu_fn = ALU_MUL;
      OPC_SHR:   ctrl.alu_fn = ALU_SHR;
      OPC_LOAD: begin
        ra_a        = BASE_REG;
        ctrl.b_imm  = 1'b1;
        ctrl.wb_sel = WB_MEM;
      end
      OPC_STORE: begin
        ra_a        = BASE_REG;
        ra_b        = f_dst;
        ctrl.b_imm  = 1'b1;
        ctrl.rf_we  = 1'b0;
        ctrl.mem_we = 1'b1;
      end
      OPC_BRZ: begin
        ra_b            = f_dst;
        ctrl.rf_we      = 1'b0;
        ctrl.br_on_zero = 1'b1;
      end
      OPC_BRNZ: begin
        ra_b          = f_dst;
        ctrl.rf_we    = 1'b0;
        ctrl.br_on_nz = 1'b1;
      end
      OPC_UPPER: ctrl.wb_sel = WB_UPPER;
      OPC_ADDI: begin
        ra_a       = f_dst;
        ctrl.b_imm = 1'b1;
      end
      OPC_JLINK: begin
        ctrl.wb_sel = WB_LINK;
        ctrl.jump   = 1'b1;
      end
      default: ctrl.alu_fn = ALU_ADD;
    endcase
  end

endmodule

// File: rtl/sc16_regfile.sv
module sc16_regfile #(
  parameter int unsigned DW   = 16,
  parameter int unsigned NREG = 16,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  output logic [DW-1:0] rd_a,
  output logic [DW-1:0] rd_b,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd
);

  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && (wa != '0)) begin
      regs[wa] <= wd;
    end
  end

  assign rd_a = regs[ra_a];
  assign rd_b = regs[ra_b];

  AST_ZERO_REG_READ: assert property (@(posedge clk) disable iff (rst)
    (ra_a == '0) |-> (rd_a == '0)); // R3

  AST_ZERO_REG_WRITE: assert property (@(posedge clk) disable iff (rst)
    (we && wa == '0) |=> (rd_b == '0 || ra_b != '0)); // R3

endmodule

// File: rtl/sc16_alu.sv
module sc16_alu
  import sc16_pkg::*;
#(
  parameter int unsigned DW = 16,
  localparam int unsigned SHW = $clog2(DW)
) (
  input  alu_fn_e       fn,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);

  logic lt;
  assign lt = $signed(a) < $signed(b);

  always_comb begin
    case (fn)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_XOR: y = a ^ b;
      ALU_SLT: y = {{(DW-1){1'b0}}, lt};
      ALU_SHL: y = a << b[SHW-1:0];
      ALU_MUL: y = a * b;
      ALU_SHR: y = a >> b[SHW-1:0];
      default: y = a + b;
    endcase
  end

endmodule

// File: rtl/sc16_core.sv
module sc16_core
  import sc16_pkg::*;
#(
  parameter int unsigned DW       = 16,
  parameter int unsigned NREG     = 16,
  parameter int unsigned BASE_REG = 13,
  localparam int unsigned RAW     = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [DW-1:0] imem_addr,
  input  logic [15:0]   imem_data,
  output logic [DW-1:0] dmem_addr,
  output logic [DW-1:0] dmem_wdata,
  output logic          dmem_we,
  input  logic [DW-1:0] dmem_rdata
);

  logic [DW-1:0]     pc;
  logic [DW-1:0]     pc_inc;
  logic [DW-1:0]     pc_next;
  ctrl_t             ctrl;
  logic [RAW-1:0]    ra_a, ra_b, wa;
  logic [IMM_W-1:0]  imm8;
  logic [DW-1:0]     rd_a, rd_b;
  logic [DW-1:0]     simm, upper_val, b_op, alu_y, wd;
  logic              taken;

  sc16_decode #(.BASE_REG(RIDX_W'(BASE_REG))) i_decode (
    .insn (imem_data),
    .ctrl (ctrl),
    .ra_a (ra_a),
    .ra_b (ra_b),
    .wa   (wa),
    .imm8 (imm8)
  );

  sc16_regfile #(.DW(DW), .NREG(NREG)) i_regfile (
    .clk  (clk),
    .rst  (rst),
    .ra_a (ra_a),
    .ra_b (ra_b),
    .rd_a (rd_a),
    .rd_b (rd_b),
    .we   (ctrl.rf_we & ~rst),
    .wa   (wa),
    .wd   (wd)
  );

  assign simm      = {{(DW-IMM_W){imm8[IMM_W-1]}}, imm8};
  assign upper_val = {imm8, {(DW-IMM_W){1'b0}}};
  assign b_op      = ctrl.b_imm ? simm : rd_b;

  sc16_alu #(.DW(DW)) i_alu (
    .fn (ctrl.alu_fn),
    .a  (rd_a),
    .b  (b_op),
    .y  (alu_y)
  );

  always_comb begin
    case (ctrl.wb_sel)
      WB_MEM:   wd = dmem_rdata;
      WB_LINK:  wd = pc_inc;
      WB_UPPER: wd = upper_val;
      default:  wd = alu_y;
    endcase
  end

  assign pc_inc = pc + 1'b1;
  assign taken  = (ctrl.br_on_zero && (rd_b == '0)) ||
                  (ctrl.br_on_nz   && (rd_b != '0));

  always_comb begin
    if (ctrl.jump)  pc_next = rd_a;
    else if (taken) pc_next = pc_inc + simm;
    else            pc_next = pc_inc;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end

  assign imem_addr  = pc;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rd_b;
  assign dmem_we    = ctrl.mem_we & ~rst;

  AST_RESET_PC: assert property (@(posedge clk)
    rst |=> (imem_addr == '0)); // R2

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.jump && !taken) |=> (imem_addr == $past(imem_addr) + DW'(1))); // R11

  AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (rst)
    taken |=> (imem_addr == $past(imem_addr) + DW'(1) + $past(simm))); // R7

  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
    (imem_data[15:12] == 4'hF) |=> (imem_addr == $past(rd_a))); // R10

  AST_STORE_ONLY_WE: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> (imem_data[15:12] == 4'h9)); // R6

endmodule

// File: tb/test_sc16_core.sv
module test_sc16_core;

  localparam int CLK_PERIOD = 10;
  localparam int MW = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clr_req = 1'b0;
  logic [15:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;
  logic [15:0] imem [MW];
  logic [15:0] dmem [MW];
  int          n_chk = 0;
  int          n_bad = 0;
  int          n_wr = 0;
  int          plen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc16_core i_sc16_core (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_data  (imem_data),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_we    (dmem_we),
    .dmem_rdata (dmem_rdata)
  );

  assign imem_data  = imem[imem_addr[7:0]];
  assign dmem_rdata = dmem[dmem_addr[7:0]];

  function automatic logic [15:0] fillv(input int i);
    return {8'(i) ^ 8'h5A, 8'(i)};
  endfunction

  always @(posedge clk) begin
    if (clr_req) begin
      for (int i = 0; i < MW; i++) dmem[i] <= fillv(i);
      n_wr <= 0;
    end else if (!rst && dmem_we) begin
      dmem[dmem_addr[7:0]] <= dmem_wdata;
      n_wr <= n_wr + 1;
    end
  end

  function automatic logic [15:0] fr(input int op, input int d, input int s, input int t);
    return {4'(op), 4'(d), 4'(s), 4'(t)};
  endfunction

  function automatic logic [15:0] fi(input int op, input int d, input int imm);
    return {4'(op), 4'(d), 8'(imm)};
  endfunction

  function automatic logic [15:0] exp_alu(input int op, input logic [15:0] a, input logic [15:0] b);
    case (op)
      0:  return a + b;
      1:  return a - b;
      2:  return a & b;
      3:  return a | b;
      4:  return a ^ b;
      5:  return ($signed(a) < $signed(b)) ? 16'd1 : 16'd0;
      6:  return a << b[3:0];
      7:  return a * b;
      default: return a >> b[3:0];
    endcase
  endfunction

  task automatic emit(input logic [15:0] w);
    imem[plen[7:0]] = w;
    plen++;
  endtask

  task automatic li(input int d, input logic [15:0] v);
    logic [7:0] hi;
    hi = v[15:8] + {7'd0, v[7]};
    emit(fi(12, d, hi));
    emit(fi(13, d, v[7:0]));
  endtask

  task automatic new_prog();
    plen = 0;
    for (int i = 0; i < MW; i++) imem[i] = fi(10, 0, 8'hFF);
  endtask

  task automatic start();
    @(negedge clk);
    rst = 1'b1;
    clr_req = 1'b1;
    @(posedge clk);
    #1 clr_req = 1'b0;
    @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic run(input int cycles);
    start();
    repeat (cycles) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL R12 watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  logic [15:0] vals [7] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234, 16'h0093};
  int          alu_ops [9] = '{0, 1, 2, 3, 4, 5, 6, 7, 14};

  initial begin
    // R2 R11: reset state and sequential fetch, registers dumped by stores
    new_prog();
    for (int k = 1; k < 16; k++) emit(fi(9, k, k));
    start();
    @(negedge clk); check("R2 pc after reset", imem_addr, 16'd0);
    @(negedge clk); check("R11 pc step 1", imem_addr, 16'd1);
    @(negedge clk); check("R11 pc step 2", imem_addr, 16'd2);
    repeat (20) @(posedge clk);
    @(negedge clk);
    for (int k = 1; k < 16; k++) check($sformatf("R2 reg %0d cleared", k), dmem[k], 16'd0);
    check("R6 store count", 16'(n_wr), 16'd15);
    check("R6 untouched word", dmem[0], fillv(0));

    // R4 R1: register-form sweep over operand pairs
    for (int ia = 0; ia < 7; ia++) begin
      for (int ib = 0; ib < 7; ib++) begin
        new_prog();
        li(1, vals[ia]);
        li(2, vals[ib]);
        li(13, 16'h0020);
        for (int k = 0; k < 9; k++) begin
          emit(fr(alu_ops[k], 3, 1, 2));
          emit(fi(9, 3, k));
        end
        run(30);
        for (int k = 0; k < 9; k++)
          check($sformatf("R4 op %0d a=%h b=%h", alu_ops[k], vals[ia], vals[ib]),
                dmem[8'h20 + k], exp_alu(alu_ops[k], vals[ia], vals[ib]));
      end
    end

    // R3: writes aimed at register 0 are dropped
    new_prog();
    li(13, 16'h0020);
    emit(fi(12, 0, 8'h12));
    emit(fi(13, 0, 5));
    emit(fr(0, 0, 13, 13));
    emit(fi(9, 0, 0));
    emit(fr(0, 4, 0, 13));
    emit(fi(9, 4, 1));
    emit(fi(8, 0, 2));
    emit(fi(9, 0, 3));
    run(20);
    check("R3 r0 after writes", dmem[8'h20], 16'd0);
    check("R3 r0 as operand", dmem[8'h21], 16'h0020);
    check("R3 r0 after load", dmem[8'h23], 16'd0);

    // R5: loads with negative and positive offsets from r13
    new_prog();
    li(13, 16'h0040);
    emit(fi(8, 5, -2));
    emit(fi(8, 6, 127));
    emit(fi(8, 7, -64));
    li(13, 16'h0080);
    emit(fi(9, 5, 0));
    emit(fi(9, 6, 1));
    emit(fi(9, 7, 2));
    run(20);
    check("R5 load -2", dmem[8'h80], fillv(8'h3E));
    check("R5 load +127", dmem[8'h81], fillv(8'hBF));
    check("R5 load -64", dmem[8'h82], fillv(8'h00));

    // R7: taken and not-taken branches on zero and nonzero
    new_prog();
    li(2, 16'd5);
    li(13, 16'h0060);
    emit(fi(10, 1, 1));
    emit(fi(13, 3, 1));
    emit(fi(13, 3, 2));
    emit(fi(11, 1, 1));
    emit(fi(13, 3, 4));
    emit(fi(11, 2, 1));
    emit(fi(13, 3, 8));
    emit(fi(10, 2, 1));
    emit(fi(13, 3, 16));
    emit(fi(9, 3, 0));
    run(25);
    check("R7 branch pattern", dmem[8'h60], 16'd22);

    // R10: jump and link, bits 3..0 nonzero and ignored
    new_prog();
    li(8, 16'd7);
    li(13, 16'h0070);
    emit(fr(15, 7, 8, 15));
    emit(fi(13, 3, 1));
    emit(fi(13, 3, 2));
    emit(fi(9, 7, 0));
    emit(fi(9, 3, 1));
    run(20);
    check("R10 link value", dmem[8'h70], 16'd5);
    check("R10 skipped path", dmem[8'h71], 16'd0);

    // R8 R9 R12: upper byte load and signed add
    new_prog();
    li(13, 16'h0090);
    emit(fi(12, 1, 8'hBF));
    emit(fi(13, 1, -17));
    emit(fi(9, 1, 0));
    emit(fi(12, 2, 8'hFF));
    emit(fi(9, 2, 1));
    emit(fi(13, 2, 8'h7F));
    emit(fi(9, 2, 2));
    emit(fi(12, 4, 0));
    emit(fi(13, 4, 8'hFF));
    emit(fi(9, 4, 3));
    emit(fi(13, 4, 1));
    emit(fi(9, 4, 4));
    run(25);
    check("R12 constant pair", dmem[8'h90], 16'hBEEF);
    check("R8 upper unsigned", dmem[8'h91], 16'hFF00);
    check("R9 add positive", dmem[8'h92], 16'hFF7F);
    check("R9 add minus one", dmem[8'h93], 16'hFFFF);
    check("R9 wrap to zero", dmem[8'h94], 16'h0000);

    // R12: summing loop with backward branch
    new_prog();
    li(13, 16'h00A0);
    li(1, 16'd0);
    li(2, 16'd0);
    li(3, 16'd8);
    emit(fi(13, 1, 1));
    emit(fr(0, 2, 2, 1));
    emit(fr(1, 4, 3, 1));
    emit(fi(11, 4, -4));
    emit(fr(0, 9, 2, 0));
    emit(fi(9, 9, 0));
    run(60);
    check("R12 sum 1..8", dmem[8'hA0], 16'd36);
    check("R12 single store", 16'(n_wr), 16'd1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule